// File: doc/BRIEF.md
# Security-Aware Track Head Parking Selector

This block sits beside one set of a last-level cache built on shift-based track storage, where all ways of the set share a single access port and reaching a way costs a number of shift steps. When an access to the set finishes, the block decides where the track head should rest until the next access. It then issues a park command that carries the target way and the number of shift steps needed to reach it.

In the protected mode, the resting point is the most recently used valid line among the lines of the least-privileged security level present in the set. A sender at a higher level therefore cannot leave the head in a place that a lower-level receiver can later measure. Two other modes are selectable. One leaves the head where the access ended; it is fast but offers no protection. The other always returns the head to one programmable home way. The block also keeps a recency rank per line and updates it on every access. Each line's valid bit and security level are written through a small metadata port.

Top module: `track_park_sel`

## Requirements
- R1: In protected mode (mode_i 0, and also 3), an access-done pulse makes park_req_o high in the next cycle. The park way is the valid line with the highest recency rank among the valid lines whose 2-bit level is the minimum present (level 0 is least privileged). The ranks used are those after the access's own rank update.
- R2: Ranks form a permutation of 0..NWAYS-1 and reset to rank i for way i. An access sets the touched way's rank to NWAYS-1 (binary 111 for eight ways). Every way ranked above the touched way's old rank drops by one, and the rest keep their rank.
- R3: Lines whose valid bit is 0 never become the protected-mode target. If no line is valid, the target is way 0.
- R4: park_shift_o equals the absolute difference between the accessed way and the park way.
- R5: In lazy mode (mode_i 1), an access issues no park request, and the head stays on the accessed way.
- R6: In fixed mode (mode_i 2), the park way is the home_way_i value sampled with the access-done pulse.
- R7: head_way_o takes the accessed way on an access-done pulse and the park way on a cycle with park_ack_i high while a request is pending. It holds otherwise. The request, with its way and shift, stays up until acknowledged.
- R8: After reset, head_way_o is 0, no request is pending and all lines are invalid.
- R9: A metadata write sets the valid bit and level of one way. The new values are used by every access-done pulse in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Parking mode: 0 and 3 protected, 1 lazy, 2 fixed |
| home_way_i | input | WAY_W | Home way for fixed mode |
| meta_we_i | input | 1 | Metadata write strobe |
| meta_way_i | input | WAY_W | Way written by the metadata port |
| meta_valid_i | input | 1 | Valid bit to store |
| meta_level_i | input | LVL_W | Security level to store |
| acc_done_i | input | 1 | One-cycle pulse when an access to the set completes |
| acc_way_i | input | WAY_W | Way the access touched |
| park_ack_i | input | 1 | Shifter has finished the park move |
| park_req_o | output | 1 | Park command pending |
| park_way_o | output | WAY_W | Way to park on |
| park_shift_o | output | WAY_W | Shift steps from accessed way to park way |
| head_way_o | output | WAY_W | Way currently under the access port |

## Verification
The assertions assume that the access-done pulse is a single cycle and arrives only while no park request is outstanding. They also assume that park_ack_i is raised only while park_req_o is high. Metadata writes are assumed never to share a cycle with an access-done pulse. The stimulus runs in transactions that keep to these rules. Each access is driven, held for a random number of cycles while the request is pending, and then acknowledged. Metadata writes are issued in separate cycles. Within those transactions, modes, ways, levels, valid bits and home ways are drawn at random from a fixed seed. Directed cases cover an empty set, a lone low-level line, and invalidation of the current favourite.

// File: rtl/tps_pkg.sv
package tps_pkg;

  typedef enum logic [1:0] {
    PM_GUARD   = 2'd0,
    PM_LAZY    = 2'd1,
    PM_HOME    = 2'd2,
    PM_GUARD_B = 2'd3
  } park_mode_e;

  // distance in shift steps between two positions on the track
  function automatic int unsigned way_gap(int unsigned a, int unsigned b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  // recency rank of one line after an access with the given old rank of the touched line
  function automatic int unsigned rank_after(int unsigned cur, int unsigned touched_old,
                                             bit is_touched, int unsigned top);
    if (is_touched)            return top;
    else if (cur > touched_old) return cur - 1;
    else                       return cur;
  endfunction

endpackage

// File: rtl/tps_meta_store.sv
module tps_meta_store #(
  parameter int NWAYS = 8,
  parameter int LVL_W = 2,
  parameter int WAY_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we_i,
  input  logic [WAY_W-1:0]              way_i,
  input  logic                          valid_i,
  input  logic [LVL_W-1:0]              level_i,
  output logic [NWAYS-1:0]              valid_o,
  output logic [NWAYS-1:0][LVL_W-1:0]   level_o
);

  logic [NWAYS-1:0] hit_w;

  for (genvar g = 0; g < NWAYS; g++) begin : g_line
    assign hit_w[g] = we_i && (way_i == WAY_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_o[g] <= 1'b0;
        level_o[g] <= '0;
      end else if (hit_w[g]) begin
        valid_o[g] <= valid_i;
        level_o[g] <= level_i;
      end
    end
  end

  AST_META_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (valid_o[$past(way_i)] == $past(valid_i)) && (level_o[$past(way_i)] == $past(level_i))); // R9

  AST_META_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_w)); // R9

endmodule

// File: rtl/tps_rank_keeper.sv
module tps_rank_keeper
  import tps_pkg::*;
#(
  parameter int NWAYS = 8,
  parameter int WAY_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          touch_i,
  input  logic [WAY_W-1:0]              touch_way_i,
  output logic [NWAYS-1:0][WAY_W-1:0]   rank_o,
  output logic [NWAYS-1:0][WAY_W-1:0]   rank_nxt_o
);

  localparam logic [WAY_W-1:0] TOP_RANK = WAY_W'(NWAYS - 1);

  logic [NWAYS-1:0][WAY_W-1:0] rank_q;
  logic [WAY_W-1:0]            touched_old_w;

  assign touched_old_w = rank_q[touch_way_i];

  for (genvar g = 0; g < NWAYS; g++) begin : g_rank
    always_comb begin
      if (touch_i)
        rank_nxt_o[g] = WAY_W'(rank_after(32'(rank_q[g]), 32'(touched_old_w),
                                          touch_way_i == WAY_W'(g), 32'(TOP_RANK)));
      else
        rank_nxt_o[g] = rank_q[g];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) rank_q[g] <= WAY_W'(g);
      else        rank_q[g] <= rank_nxt_o[g];
    end
  end

  assign rank_o = rank_q;

  // every rank value is held by exactly one way
  for (genvar v = 0; v < NWAYS; v++) begin : g_perm
    logic [NWAYS-1:0] holder_w;
    for (genvar i = 0; i < NWAYS; i++) begin : g_cmp
      assign holder_w[i] = (rank_q[i] == WAY_W'(v));
    end
    AST_RANK_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(holder_w) == 1); // R2
  end

  AST_TOUCH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    touch_i |=> rank_q[$past(touch_way_i)] == TOP_RANK); // R2

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !touch_i |=> $stable(rank_q)); // R2

endmodule

// File: rtl/tps_park_pick.sv
module tps_park_pick #(
  parameter int NWAYS = 8,
  parameter int LVL_W = 2,
  parameter int WAY_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NWAYS-1:0]              valid_i,
  input  logic [NWAYS-1:0][LVL_W-1:0]   level_i,
  input  logic [NWAYS-1:0][WAY_W-1:0]   rank_i,
  output logic [WAY_W-1:0]              pick_way_o,
  output logic                          any_valid_o
);

  logic [LVL_W-1:0] floor_lvl_w;
  logic [NWAYS-1:0] cand_w;
  logic [WAY_W-1:0] best_rank_w;
  logic             found_w;

  // lowest level present among valid lines
  always_comb begin
    floor_lvl_w = '1;
    for (int i = 0; i < NWAYS; i++) begin
      if (valid_i[i] && (level_i[i] < floor_lvl_w)) floor_lvl_w = level_i[i];
    end
  end

  for (genvar g = 0; g < NWAYS; g++) begin : g_cand
    assign cand_w[g] = valid_i[g] && (level_i[g] == floor_lvl_w);
  end

  // most recent candidate
  always_comb begin
    pick_way_o  = '0;
    best_rank_w = '0;
    found_w     = 1'b0;
    for (int i = 0; i < NWAYS; i++) begin
      if (cand_w[i] && (!found_w || (rank_i[i] > best_rank_w))) begin
        found_w     = 1'b1;
        best_rank_w = rank_i[i];
        pick_way_o  = WAY_W'(i);
      end
    end
  end

  assign any_valid_o = |valid_i;

  AST_PICK_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    any_valid_o |-> valid_i[pick_way_o]); // R3

  AST_EMPTY_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !any_valid_o |-> (pick_way_o == '0)); // R3

  AST_PICK_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    any_valid_o |-> (level_i[pick_way_o] == floor_lvl_w)); // R1

endmodule

// File: rtl/track_park_sel.sv
module track_park_sel
  import tps_pkg::*;
#(
  parameter int NWAYS = 8,
  parameter int LVL_W = 2,
  localparam int WAY_W = $clog2(NWAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic [WAY_W-1:0] home_way_i,
  input  logic             meta_we_i,
  input  logic [WAY_W-1:0] meta_way_i,
  input  logic             meta_valid_i,
  input  logic [LVL_W-1:0] meta_level_i,
  input  logic             acc_done_i,
  input  logic [WAY_W-1:0] acc_way_i,
  input  logic             park_ack_i,
  output logic             park_req_o,
  output logic [WAY_W-1:0] park_way_o,
  output logic [WAY_W-1:0] park_shift_o,
  output logic [WAY_W-1:0] head_way_o
);

  logic [NWAYS-1:0]            valid_w;
  logic [NWAYS-1:0][LVL_W-1:0] level_w;
  logic [NWAYS-1:0][WAY_W-1:0] rank_w;
  logic [NWAYS-1:0][WAY_W-1:0] rank_nxt_w;
  logic [WAY_W-1:0]            guard_way_w;
  logic                        any_valid_w;
  logic [WAY_W-1:0]            target_w;
  logic                        issue_w;
  logic                        park_fire_w;
  park_mode_e                  mode_w;

  logic             req_q;
  logic [WAY_W-1:0] pway_q;
  logic [WAY_W-1:0] pshift_q;
  logic [WAY_W-1:0] head_q;

  assign mode_w = park_mode_e'(mode_i);

  tps_meta_store #(.NWAYS(NWAYS), .LVL_W(LVL_W), .WAY_W(WAY_W)) i_meta (
    .clk(clk), .rst_n(rst_n), .we_i(meta_we_i), .way_i(meta_way_i),
    .valid_i(meta_valid_i), .level_i(meta_level_i),
    .valid_o(valid_w), .level_o(level_w)
  );

  tps_rank_keeper #(.NWAYS(NWAYS), .WAY_W(WAY_W)) i_rank (
    .clk(clk), .rst_n(rst_n), .touch_i(acc_done_i), .touch_way_i(acc_way_i),
    .rank_o(rank_w), .rank_nxt_o(rank_nxt_w)
  );

  // selection sees the ranks as they stand after this access
  tps_park_pick #(.NWAYS(NWAYS), .LVL_W(LVL_W), .WAY_W(WAY_W)) i_pick (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_w), .level_i(level_w),
    .rank_i(rank_nxt_w), .pick_way_o(guard_way_w), .any_valid_o(any_valid_w)
  );

  always_comb begin
    unique case (mode_w)
      PM_LAZY: target_w = acc_way_i;
      PM_HOME: target_w = home_way_i;
      default: target_w = guard_way_w;
    endcase
  end

  assign issue_w     = acc_done_i && (mode_w != PM_LAZY);
  assign park_fire_w = req_q && park_ack_i && !acc_done_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      pway_q   <= '0;
      pshift_q <= '0;
      head_q   <= '0;
    end else if (acc_done_i) begin
      head_q <= acc_way_i;
      req_q  <= issue_w;
      if (issue_w) begin
        pway_q   <= target_w;
        pshift_q <= WAY_W'(way_gap(32'(acc_way_i), 32'(target_w)));
      end
    end else if (park_fire_w) begin
      head_q <= pway_q;
      req_q  <= 1'b0;
    end
  end

  assign park_req_o   = req_q;
  assign park_way_o   = pway_q;
  assign park_shift_o = pshift_q;
  assign head_way_o   = head_q;

  AST_REQ_FOLLOWS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done_i && (mode_i != 2'd1)) |=> park_req_o); // R1

  AST_LAZY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done_i && (mode_i == 2'd1)) |=> (!park_req_o && (head_way_o == $past(acc_way_i)))); // R5

  AST_HOME_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done_i && (mode_i == 2'd2)) |=> (park_way_o == $past(home_way_i))); // R6

  AST_SHIFT_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done_i && (mode_i != 2'd1)) |=>
      (park_shift_o == ((head_way_o > park_way_o) ? (head_way_o - park_way_o)
                                                  : (park_way_o - head_way_o)))); // R4

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (park_req_o && !park_ack_i && !acc_done_i) |=>
      (park_req_o && $stable(park_way_o) && $stable(park_shift_o) && $stable(head_way_o))); // R7

  AST_HEAD_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    park_fire_w |=> (!park_req_o && (head_way_o == $past(park_way_o)))); // R7

endmodule

// File: tb/test_track_park_sel.sv
`timescale 1ns/1ps
module test_track_park_sel;

  localparam int NW = 8;
  localparam int WW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode_i = 2'd0;
  logic [WW-1:0] home_way_i = '0;
  logic          meta_we_i = 1'b0;
  logic [WW-1:0] meta_way_i = '0;
  logic          meta_valid_i = 1'b0;
  logic [1:0]    meta_level_i = '0;
  logic          acc_done_i = 1'b0;
  logic [WW-1:0] acc_way_i = '0;
  logic          park_ack_i = 1'b0;
  logic          park_req_o;
  logic [WW-1:0] park_way_o;
  logic [WW-1:0] park_shift_o;
  logic [WW-1:0] head_way_o;

  track_park_sel i_track_park_sel (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .home_way_i(home_way_i),
    .meta_we_i(meta_we_i), .meta_way_i(meta_way_i), .meta_valid_i(meta_valid_i),
    .meta_level_i(meta_level_i), .acc_done_i(acc_done_i), .acc_way_i(acc_way_i),
    .park_ack_i(park_ack_i), .park_req_o(park_req_o), .park_way_o(park_way_o),
    .park_shift_o(park_shift_o), .head_way_o(head_way_o)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int m_valid [NW];
  int m_lvl   [NW];
  int m_rank  [NW];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_guard();
    int lowest = 99;
    int best = -1;
    int way = 0;
    for (int i = 0; i < NW; i++)
      if (m_valid[i] != 0 && m_lvl[i] < lowest) lowest = m_lvl[i];
    for (int i = 0; i < NW; i++)
      if (m_valid[i] != 0 && m_lvl[i] == lowest && m_rank[i] > best) begin
        best = m_rank[i];
        way = i;
      end
    return way;
  endfunction

  function automatic int steps(int a, int b);
    int d = a - b;
    return (d < 0) ? -d : d;
  endfunction

  task automatic meta(int way, int v, int lvl);
    @(negedge clk);
    meta_we_i = 1'b1; meta_way_i = WW'(way); meta_valid_i = v[0]; meta_level_i = 2'(lvl);
    @(negedge clk);
    meta_we_i = 1'b0;
    m_valid[way] = v;
    m_lvl[way] = lvl;
  endtask

  task automatic access(int way, int mode, int home, int hold, string tag);
    int old = m_rank[way];
    int exp;
    for (int i = 0; i < NW; i++) begin
      if (i == way)             m_rank[i] = NW - 1;
      else if (m_rank[i] > old) m_rank[i] = m_rank[i] - 1;
    end
    if (mode == 2) exp = home;
    else           exp = exp_guard();
    @(negedge clk);
    acc_done_i = 1'b1; acc_way_i = WW'(way); mode_i = 2'(mode); home_way_i = WW'(home);
    @(negedge clk);
    acc_done_i = 1'b0;
    chk("R7 head at accessed way", int'(head_way_o), way);
    if (mode == 1) begin
      chk("R5 lazy issues no request", int'(park_req_o), 0);
      repeat (hold) @(negedge clk);
      chk("R5 lazy head stays", int'(head_way_o), way);
    end else begin
      chk("R1 request raised", int'(park_req_o), 1);
      chk(tag, int'(park_way_o), exp);
      chk("R4 shift count", int'(park_shift_o), steps(way, exp));
      repeat (hold) @(negedge clk);
      chk("R7 request held", int'(park_req_o), 1);
      chk("R7 head held before ack", int'(head_way_o), way);
      park_ack_i = 1'b1;
      @(negedge clk);
      park_ack_i = 1'b0;
      chk("R7 head at park way", int'(head_way_o), exp);
      chk("R7 request cleared", int'(park_req_o), 0);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NW; i++) begin
      m_valid[i] = 0; m_lvl[i] = 0; m_rank[i] = i;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset head", int'(head_way_o), 0);
    chk("R8 reset request", int'(park_req_o), 0);

    // R3: empty set parks at way 0
    access(5, 0, 0, 0, "R3 empty set parks way 0");
    // R8: lines start invalid, so one valid line wins
    meta(4, 1, 3);
    access(2, 0, 0, 1, "R8 only written line valid");
    // R2 / R1: all valid at one level, latest access wins
    for (int i = 0; i < NW; i++) meta(i, 1, 1);
    access(3, 0, 0, 0, "R2 touched line ranked top");
    access(5, 3, 0, 2, "R1 alternate guard code");
    // R3: invalidating the favourite hands the target to the next rank
    meta(5, 0, 1);
    access(5, 2, 6, 0, "R6 home way");
    access(1, 1, 0, 1, "R5 lazy");
    meta(1, 0, 1);
    access(1, 0, 0, 0, "R3 invalid line skipped");
    // R9 / R1: a single least-privileged line wins regardless of rank
    meta(6, 1, 0);
    access(0, 0, 0, 0, "R9 new low level line chosen");
    access(7, 2, 0, 1, "R6 home way zero");

    for (int n = 0; n < 400; n++) begin
      int r = int'($urandom_range(0, 9));
      if (r < 3) begin
        meta(int'($urandom_range(0, NW - 1)), int'($urandom_range(0, 3)) != 0 ? 1 : 0,
             int'($urandom_range(0, 3)));
      end else begin
        int md = int'($urandom_range(0, 9));
        int mode = (md < 6) ? 0 : (md == 6) ? 1 : (md == 7) ? 2 : 3;
        access(int'($urandom_range(0, NW - 1)), mode, int'($urandom_range(0, NW - 1)),
               int'($urandom_range(0, 3)),
               (mode == 2) ? "R6 random home" : "R1 random guarded target");
      end
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule